// File: doc/BRIEF.md
# Multi-Lane Link Impairment Emulator

This block takes the place of a multi-lane serial physical layer during verification of retransmission logic. On every clock each lane accepts one transmit symbol. All lanes are pushed through a delay line of fixed depth and come out on the receive side. Two 32-bit run-time controls act on the symbols as they leave the delay line. The first corrupts one bit of one symbol at a chosen average rate. The second blanks every Nth output cycle across all lanes.

The error decision comes from a pseudo-random sequence that starts from a fixed value at reset. The drop decision comes from a plain counter. Any stimulus therefore produces the same impairments on every run. Two event pulses mark each corruption and each drop, so a bench can count them exactly. A link-up output is tied high.

A small state machine tracks warm-up. After reset it sits in state FILL while the delay line fills, and receive outputs stay quiet. The transition FILL→RUN occurs on the clock edge that ends the LATENCY-th cycle after reset release. The machine then stays in RUN until the next reset, which is the transition RUN→FILL.

Top module: `lane_impair_emu`

## Requirements
- R1: Lane count (LANES, default 4), symbol width (SYM_W, default 8) and delay (LATENCY, default 4) are parameters. For the first LATENCY cycles after reset release, rx_sym is all zeros, rx_valid is all low, and flip_evt and drop_evt are low.
- R2: With err_rate = 0 and drop_period = 0, in every cycle c >= LATENCY each lane's rx symbol equals that lane's tx symbol from cycle c-LATENCY, bit for bit, and rx_valid is all high. Lane k occupies bits [k*SYM_W +: SYM_W] of both vectors.
- R3: A symbol is corrupted in an output cycle when the block is past warm-up, err_rate is nonzero, no drop occurs and the current random value modulo err_rate is zero. err_rate = 0 never corrupts, and err_rate = 1 corrupts in every non-dropped output cycle.
- R4: A corruption inverts exactly one bit of one lane. The lane index is random[15:8] mod LANES and the bit index is random[7:0] mod SYM_W.
- R5: The random value is a 32-bit shift register loaded with 0x0000ACE1 while reset is asserted. On each clock edge out of reset it shifts left by one, and the new bit 0 is the XOR of bits 31, 21, 1 and 0.
- R6: With drop_period = N > 0, a counter of output cycles past warm-up drops the Nth cycle and then restarts. The counter rests at zero while N is 0. In a dropped cycle all lanes output zero with rx_valid low, and drop_evt is high. N = 8 gives exactly 10 drops in 80 consecutive cycles, and N = 1 drops every cycle.
- R7: When a drop and a corruption fall in the same cycle, the drop wins: flip_evt stays low and no bit is inverted.
- R8: link_up is high in every cycle, including during reset.
- R9: flip_evt and drop_evt are high in exactly the cycle whose rx outputs carry the corruption or the drop. Both controls act on the symbols emerging in the cycle in which they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_sym | input | LANES*SYM_W | Transmit symbols, lane k at bits [k*SYM_W +: SYM_W] |
| err_rate | input | 32 | Error-rate control (0 off, N ≈ one in N) |
| drop_period | input | 32 | Drop control (0 off, N drops every Nth cycle) |
| rx_sym | output | LANES*SYM_W | Delayed and impaired receive symbols |
| rx_valid | output | LANES | Per-lane receive-valid |
| link_up | output | 1 | Link indication, always high |
| flip_evt | output | 1 | Pulse: a bit was inverted this cycle |
| drop_evt | output | 1 | Pulse: this cycle's symbols were dropped |

## Verification
The hardest case to reach is a cycle in which the drop counter expires and the random source also calls for a corruption. At moderate rates the two rarely line up. The stimulus forces the overlap by setting err_rate to 1, so every output cycle is a corruption candidate, together with a short drop period. Every drop cycle then exercises the precedence rule. The scoreboard models the random sequence from its stated seed and polynomial, which lets it predict the exact lane and bit of every flip under low, high and saturated error rates.

// File: rtl/lid_pkg.sv
package lid_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } lid_state_e;

    localparam logic [31:0] LID_SEED = 32'h0000_ACE1;

    function automatic logic [31:0] lid_shift(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction
endpackage

// File: rtl/lid_warmup_fsm.sv
module lid_warmup_fsm #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic run
);
    import lid_pkg::*;

    localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

    lid_state_e             state_q, state_d;
    logic [CNT_W-1:0]       fill_q, fill_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_FILL: begin
                fill_d = fill_q + 1'b1;
                if (fill_q == LAST) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                fill_d = fill_q;
            end
            default: state_d = ST_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_FILL: run = 1'b0;
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end
endmodule

// File: rtl/lid_delay_line.sv
module lid_delay_line #(
    parameter int DW      = 32,
    parameter int LATENCY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] pipe_q [LATENCY];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LATENCY; s++) begin
                pipe_q[s] <= '0;
            end
        end else begin
            pipe_q[0] <= din;
            for (int s = 1; s < LATENCY; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign dout = pipe_q[LATENCY-1];
endmodule

// File: rtl/lid_lfsr.sv
module lid_lfsr (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] rnd
);
    import lid_pkg::*;

    logic [31:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= LID_SEED;
        end else begin
            sr_q <= lid_shift(sr_q);
        end
    end

    assign rnd = sr_q;
endmodule

// File: rtl/lid_drop_sched.sv
module lid_drop_sched (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic [31:0] period,
    output logic        drop
);
    logic [31:0] cnt_q;
    logic        armed;

    always_comb begin
        armed = run && (period != 32'd0);
        drop  = armed && (cnt_q >= period - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!armed) begin
            cnt_q <= '0;
        end else if (drop) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 32'd1;
        end
    end
endmodule

// File: rtl/lane_impair_emu.sv
module lane_impair_emu #(
    parameter int LANES   = 4,
    parameter int SYM_W   = 8,
    parameter int LATENCY = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*SYM_W-1:0]   tx_sym,
    input  logic [31:0]              err_rate,
    input  logic [31:0]              drop_period,
    output logic [LANES*SYM_W-1:0]   rx_sym,
    output logic [LANES-1:0]         rx_valid,
    output logic                     link_up,
    output logic                     flip_evt,
    output logic                     drop_evt
);
    localparam int DW = LANES * SYM_W;

    logic          run;
    logic [DW-1:0] delayed;
    logic [DW-1:0] flip_mask;
    logic [31:0]   rnd;
    logic [31:0]   rem;
    logic [31:0]   lane_sel;
    logic [31:0]   bit_sel;
    logic          hit;
    logic          drop_go;
    logic          flip_go;

    lid_warmup_fsm #(.LATENCY(LATENCY)) fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    lid_delay_line #(.DW(DW), .LATENCY(LATENCY)) dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tx_sym),
        .dout  (delayed)
    );

    lid_lfsr rng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    lid_drop_sched drp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .period (drop_period),
        .drop   (drop_go)
    );

    // error decision and flip position
    always_comb begin
        rem      = (err_rate != 32'd0) ? (rnd % err_rate) : 32'd1;
        hit      = run && (err_rate != 32'd0) && (rem == 32'd0);
        flip_go  = hit && !drop_go;
        lane_sel = 32'(rnd[15:8]) % 32'(LANES);
        bit_sel  = 32'(rnd[7:0]) % 32'(SYM_W);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar b = 0; b < SYM_W; b++) begin : g_bit
            assign flip_mask[l*SYM_W + b] = flip_go
                                          && (lane_sel == 32'(l))
                                          && (bit_sel  == 32'(b));
        end
    end

    always_comb begin
        if (!run || drop_go) begin
            rx_sym   = '0;
            rx_valid = '0;
        end else begin
            rx_sym   = delayed ^ flip_mask;
            rx_valid = '1;
        end
        flip_evt = flip_go;
        drop_evt = drop_go;
        link_up  = 1'b1;
    end
endmodule

// File: rtl/lid_checker.sv
module lid_checker #(
    parameter int LANES   = 4,
    parameter int SYM_W   = 8,
    parameter int LATENCY = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [31:0]            err_rate,
    input logic [31:0]            drop_period,
    input logic [LANES*SYM_W-1:0] rx_sym,
    input logic [LANES-1:0]       rx_valid,
    input logic                   flip_evt,
    input logic                   drop_evt,
    input logic                   run
);
    logic [31:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q < 32'(LATENCY)) begin
            since_q <= since_q + 32'd1;
        end
    end

    // R1
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < 32'(LATENCY)) |-> (rx_valid == '0 && !flip_evt && !drop_evt));

    // R7
    drop_beats_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |-> !flip_evt);

    // R6
    drop_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |-> (rx_valid == '0 && rx_sym == '0));

    // R3
    no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rate == 32'd0) |-> !flip_evt);

    // R6
    every_cycle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && drop_period == 32'd1) |-> drop_evt);

    // R9
    valid_when_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !drop_evt) |-> (rx_valid == '1));
endmodule

bind lane_impair_emu lid_checker #(
    .LANES   (LANES),
    .SYM_W   (SYM_W),
    .LATENCY (LATENCY)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_rate    (err_rate),
    .drop_period (drop_period),
    .rx_sym      (rx_sym),
    .rx_valid    (rx_valid),
    .flip_evt    (flip_evt),
    .drop_evt    (drop_evt),
    .run         (run)
);

// File: tb/lane_impair_emu_tb_top.sv
`timescale 1ns/1ps
module lane_impair_emu_tb_top;
    localparam int LANES   = 4;
    localparam int SYM_W   = 8;
    localparam int LATENCY = 4;
    localparam int DW      = LANES * SYM_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DW-1:0]   tx_sym = '0;
    logic [31:0]     err_rate = '0;
    logic [31:0]     drop_period = '0;
    logic [DW-1:0]   rx_sym;
    logic [LANES-1:0] rx_valid;
    logic            link_up;
    logic            flip_evt;
    logic            drop_evt;

    int n_run  = 0;
    int n_fail = 0;
    int drops_seen = 0;
    int flips_seen = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    lane_impair_emu #(.LANES(LANES), .SYM_W(SYM_W), .LATENCY(LATENCY)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_sym(tx_sym), .err_rate(err_rate),
        .drop_period(drop_period), .rx_sym(rx_sym), .rx_valid(rx_valid),
        .link_up(link_up), .flip_evt(flip_evt), .drop_evt(drop_evt)
    );

    function automatic logic [31:0] step(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // driver: one symbol per cycle, pushed to the scoreboard queue
    task automatic drive(input logic [DW-1:0] sym);
        tx_sym = sym;
        exp_q.push_back(sym);
        @(posedge clk);
        #1;
    endtask

    // monitor: reference model of delay, random source and drop counter
    logic [31:0] m_lfsr = 32'h0000_ACE1;
    int          m_cnt  = 0;
    int          m_cyc  = 0;

    always @(negedge clk) begin
        if (started && !done) begin
            logic [DW-1:0]    e_sym;
            logic [LANES-1:0] e_val;
            logic             e_flip, e_drop, cand;
            string            tag;
            int               ln, bt;
            e_sym = '0; e_val = '0; e_flip = 1'b0; e_drop = 1'b0; cand = 1'b0;
            tag = "R1";
            if (m_cyc >= LATENCY) begin
                e_sym = exp_q.pop_front();
                e_val = '1;
                tag = "R2";
                e_drop = (drop_period != 0) && (32'(m_cnt) >= drop_period - 1);
                cand = (err_rate != 0) && ((m_lfsr % err_rate) == 0);
                if (e_drop) begin
                    e_sym = '0; e_val = '0;
                    tag = cand ? "R7" : "R6";
                end else if (cand) begin
                    e_flip = 1'b1;
                    ln = int'(m_lfsr[15:8]) % LANES;
                    bt = int'(m_lfsr[7:0]) % SYM_W;
                    e_sym[ln*SYM_W + bt] = ~e_sym[ln*SYM_W + bt];
                    tag = "R4";
                end
                if (drop_period == 0) m_cnt = 0;
                else if (e_drop) m_cnt = 0;
                else m_cnt = m_cnt + 1;
            end
            check(tag, 64'({rx_sym, rx_valid, flip_evt, drop_evt}),
                       64'({e_sym, e_val, e_flip, e_drop}));
            check("R8", 64'(link_up), 64'd1);
            if (drop_evt) drops_seen++;
            if (flip_evt) flips_seen++;
            m_lfsr = step(m_lfsr);
            m_cyc++;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // reset state: outputs quiet, link indication high (R1, R8)
        check("R1", 64'({rx_sym, rx_valid, flip_evt, drop_evt}), 64'd0);
        check("R8", 64'(link_up), 64'd1);
        rst_n = 1'b1;
        started = 1'b1;

        // clean passthrough, several patterns (R2)
        for (int i = 0; i < 24; i++) drive(DW'(i * 32'h0101_0101));
        for (int i = 0; i < 16; i++) drive(DW'(32'hA5C3_0F96 ^ (i * 32'h1357_9BDF)));
        drive('1);
        drive('0);

        // every cycle corrupted (R3, R4, R5)
        err_rate = 32'd1;
        flips_seen = 0;
        for (int i = 0; i < 20; i++) drive(DW'(32'h5A5A_5A5A + i));
        check("R3", 64'(flips_seen), 64'd20);

        // sparse corruption, reproducible pattern (R3, R4, R5)
        err_rate = 32'd10;
        for (int i = 0; i < 300; i++) drive(DW'(i * 32'h0003_0507));

        // periodic drop, exactly 10 in 80 (R6)
        err_rate = 32'd0;
        drop_period = 32'd8;
        drops_seen = 0;
        for (int i = 0; i < 80; i++) drive(DW'(32'hC0DE_0000 + i));
        check("R6", 64'(drops_seen), 64'd10);

        // overlap of drop and corruption (R7)
        err_rate = 32'd1;
        drop_period = 32'd3;
        for (int i = 0; i < 30; i++) drive(DW'(32'h1234_5678 ^ i));

        // drop every cycle (R6, R9)
        err_rate = 32'd3;
        drop_period = 32'd1;
        drops_seen = 0;
        for (int i = 0; i < 10; i++) drive(DW'(i));
        check("R6", 64'(drops_seen), 64'd10);

        // back to clean and drain the pipe (R2)
        err_rate = 32'd0;
        drop_period = 32'd0;
        for (int i = 0; i < LATENCY + 8; i++) drive(DW'(32'hFEED_0000 | i));

        done = 1'b1;
        finish_run();
    end
endmodule